// File: doc/BRIEF.md
# Pinned-Destination Squash Recovery Tracker

In an out-of-order core, a physical register may be pinned so that several consecutive writes land in the same physical location instead of each taking a fresh register. Every pinned register holds two counters outside this block: how many writes may still be renamed onto it, and how many writes must still complete before consumers may be woken. When an instruction that was already renamed onto a pinned register is squashed, those counters have to be given back. The instruction may then be renamed again, for instance after a memory-ordering replay, and it must land on the same physical register with consistent counts.

This block keeps a small status record per in-flight instruction, indexed by its tag. It also stores that instruction's pinned destination registers. Rename, pinned-write completion and squash events update the record. On the first squash of a pinned-renamed instruction, the block emits one-cycle increment strobes toward the per-register counters. Every pinned destination gets a strobe that returns a rename credit. Destinations whose write had already completed also get a strobe that returns a completion credit. A query port reads back the status record of any tag.

Top module: `pin_squash_tracker`

## Requirements
- R1: While reset is asserted and after it is released, every entry reads back with all five status flags clear, and both strobe vectors are zero.
- R2: A rename event rewrites the entry of its tag. The renamed flag becomes 1 exactly when at least one destination lane has both its valid bit and its pinned bit set. The written, squash-done, squashed and queue-squashed flags become 0.
- R3: A completion event sets the written flag only when the entry's renamed flag is 1 and its squash-done flag is 0. Otherwise it is ignored, and the written flag keeps its value.
- R4: A squash event always sets the squashed flag of its entry. When the squash comes from the load/store queue (`sq_from_lsq` = 1), it also sets the queue-squashed flag.
- R5: When a squash hits an entry whose renamed flag is 1 and whose squash-done flag is 0, the rename-credit strobe `inc_rem_v[d]` is 1 in the cycle after the squash edge for each lane d that was valid and pinned. That lane's physical index appears on `inc_rem_preg`. Lanes that are not pinned get no strobe. Every strobe lasts exactly one cycle.
- R6: In the same restoring squash, `inc_cpl_v[d]` is also 1 for each pinned lane whenever the entry's written flag is 1. Otherwise `inc_cpl_v` stays 0.
- R7: A restoring squash sets the squash-done flag. A squash of an entry that is not pinned-renamed, or whose squash-done flag is already 1, produces no strobes at all and leaves squash-done unchanged.
- R8: When a completion and a squash for the same tag arrive in the same cycle, the completion is applied first. If the completion is accepted under R3, the squash therefore emits completion-credit strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename event valid |
| ren_tag | input | TAG_W | Tag of the renamed instruction |
| ren_dst_valid | input | NDEST | Destination lane is used |
| ren_dst_pinned | input | NDEST | Destination lane maps to a pinned register |
| ren_dst_preg | input | NDEST*PREG_W | Physical index per lane, lane d at bits d*PREG_W |
| wr_valid | input | 1 | Pinned-write completion event valid |
| wr_tag | input | TAG_W | Tag of the completing instruction |
| sq_valid | input | 1 | Squash request valid |
| sq_tag | input | TAG_W | Tag of the squashed instruction |
| sq_from_lsq | input | 1 | Squash is raised by the load/store queue |
| qry_tag | input | TAG_W | Tag whose status is read back |
| qry_squashed | output | 1 | Squashed flag of the queried entry |
| qry_lsq_squashed | output | 1 | Queue-squashed flag of the queried entry |
| qry_renamed | output | 1 | Pinned-renamed flag of the queried entry |
| qry_written | output | 1 | Pinned-written flag of the queried entry |
| qry_sqdone | output | 1 | Squash-done flag of the queried entry |
| inc_rem_v | output | NDEST | Per-lane rename-credit increment strobe |
| inc_rem_preg | output | NDEST*PREG_W | Physical index per rename-credit strobe |
| inc_cpl_v | output | NDEST | Per-lane completion-credit increment strobe |
| inc_cpl_preg | output | NDEST*PREG_W | Physical index per completion-credit strobe |

## Verification
The sweep walks every combination of lane-valid and lane-pinned bits with four histories per combination. The histories are: no completion, completion before the squash, completion in the same cycle as the squash, and completion followed by a load/store-queue squash. Unpinned patterns separate "squash marks only" from "squash restores". The no-completion and early-completion histories separate rename-credit strobes from completion-credit strobes. The same-cycle history exposes a wrong ordering between completion and squash. Every instruction is squashed a second time and then sent a late completion, which shows that restoration happens once and that squash-done freezes the written flag.

// File: rtl/pst_pkg.sv
// Shared types for the pinned-destination squash tracker.
// Assumes: one status record per in-flight instruction tag.
package pst_pkg;

    // Status flags kept for one instruction entry.
    typedef struct packed {
        logic squashed;   // squashed by any source
        logic lsq_sq;     // squashed by the load/store queue
        logic renamed;    // at least one destination is pinned
        logic written;    // the pinned write has completed
        logic sqdone;     // counters already restored after squash
    } pst_stat_t;

endpackage

// File: rtl/pst_status_table.sv
// Tag-indexed table of per-instruction status and pinned destinations.
// Applies rename, completion and squash events, completion before squash.
// Assumes: a rename never hits the same tag as a completion or squash in one cycle.
module pst_status_table
    import pst_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int NDEST  = 2,
    parameter int PREG_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ren_valid,
    input  logic [TAG_W-1:0]         ren_tag,
    input  logic [NDEST-1:0]         ren_dst_valid,
    input  logic [NDEST-1:0]         ren_dst_pinned,
    input  logic [NDEST*PREG_W-1:0]  ren_dst_preg,
    input  logic                     wr_valid,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic                     sq_valid,
    input  logic [TAG_W-1:0]         sq_tag,
    input  logic                     sq_from_lsq,
    input  logic [TAG_W-1:0]         qry_tag,
    output pst_stat_t                qry_stat,
    output pst_stat_t                sq_stat,
    output logic [NDEST-1:0]         sq_pin,
    output logic [NDEST*PREG_W-1:0]  sq_preg
);
    localparam int ENTRIES = 1 << TAG_W;

    pst_stat_t                    stat_q [ENTRIES];
    pst_stat_t                    stat_d [ENTRIES];
    logic [NDEST-1:0]             pin_q  [ENTRIES];
    logic [NDEST*PREG_W-1:0]      preg_q [ENTRIES];
    logic [NDEST-1:0]             ren_pin;
    pst_stat_t                    work;

    assign ren_pin = ren_dst_valid & ren_dst_pinned;

    // Next status per entry: rename rebuilds, else completion then squash.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            work = stat_q[e];
            if (ren_valid && ren_tag == TAG_W'(e)) begin
                work         = '0;
                work.renamed = |ren_pin;
            end else begin
                if (wr_valid && wr_tag == TAG_W'(e) && work.renamed && !work.sqdone)
                    work.written = 1'b1;
                if (sq_valid && sq_tag == TAG_W'(e)) begin
                    work.squashed = 1'b1;
                    if (sq_from_lsq)
                        work.lsq_sq = 1'b1;
                    if (work.renamed)
                        work.sqdone = 1'b1;
                end
            end
            stat_d[e] = work;
        end
    end

    // Entry storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (!rst_n) begin
                stat_q[e] <= '0;
                pin_q[e]  <= '0;
                preg_q[e] <= '0;
            end else begin
                stat_q[e] <= stat_d[e];
                if (ren_valid && ren_tag == TAG_W'(e)) begin
                    pin_q[e]  <= ren_pin;
                    preg_q[e] <= ren_dst_preg;
                end
            end
        end
    end

    // Squash-side read, with a same-cycle completion folded in first.
    always_comb begin
        sq_stat = stat_q[sq_tag];
        if (wr_valid && wr_tag == sq_tag && sq_stat.renamed && !sq_stat.sqdone)
            sq_stat.written = 1'b1;
    end

    assign sq_pin   = pin_q[sq_tag];
    assign sq_preg  = preg_q[sq_tag];
    assign qry_stat = stat_q[qry_tag];

endmodule

// File: rtl/pst_restore_gen.sv
// Builds the registered per-lane increment strobes for a restoring squash.
// Assumes: sq_stat already includes any same-cycle completion.
module pst_restore_gen
    import pst_pkg::*;
#(
    parameter int NDEST  = 2,
    parameter int PREG_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sq_valid,
    input  pst_stat_t                sq_stat,
    input  logic [NDEST-1:0]         sq_pin,
    input  logic [NDEST*PREG_W-1:0]  sq_preg,
    output logic [NDEST-1:0]         inc_rem_v,
    output logic [NDEST*PREG_W-1:0]  inc_rem_preg,
    output logic [NDEST-1:0]         inc_cpl_v,
    output logic [NDEST*PREG_W-1:0]  inc_cpl_preg
);
    logic fire;

    assign fire = sq_valid && sq_stat.renamed && !sq_stat.sqdone;

    for (genvar d = 0; d < NDEST; d++) begin : g_lane
        // One-cycle strobes and physical index for lane d.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                inc_rem_v[d]                   <= 1'b0;
                inc_cpl_v[d]                   <= 1'b0;
                inc_rem_preg[d*PREG_W +: PREG_W] <= '0;
                inc_cpl_preg[d*PREG_W +: PREG_W] <= '0;
            end else begin
                inc_rem_v[d] <= fire && sq_pin[d];
                inc_cpl_v[d] <= fire && sq_pin[d] && sq_stat.written;
                if (fire && sq_pin[d]) begin
                    inc_rem_preg[d*PREG_W +: PREG_W] <= sq_preg[d*PREG_W +: PREG_W];
                    inc_cpl_preg[d*PREG_W +: PREG_W] <= sq_preg[d*PREG_W +: PREG_W];
                end
            end
        end
    end

endmodule

// File: rtl/pin_squash_tracker.sv
// Top of the pinned-destination squash recovery tracker.
// Holds per-tag pin status and returns pin credits on the first squash.
// Assumes: the caller keeps rename and other events on distinct tags per cycle.
module pin_squash_tracker
    import pst_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int NDEST  = 2,
    parameter int PREG_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ren_valid,
    input  logic [TAG_W-1:0]         ren_tag,
    input  logic [NDEST-1:0]         ren_dst_valid,
    input  logic [NDEST-1:0]         ren_dst_pinned,
    input  logic [NDEST*PREG_W-1:0]  ren_dst_preg,
    input  logic                     wr_valid,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic                     sq_valid,
    input  logic [TAG_W-1:0]         sq_tag,
    input  logic                     sq_from_lsq,
    input  logic [TAG_W-1:0]         qry_tag,
    output logic                     qry_squashed,
    output logic                     qry_lsq_squashed,
    output logic                     qry_renamed,
    output logic                     qry_written,
    output logic                     qry_sqdone,
    output logic [NDEST-1:0]         inc_rem_v,
    output logic [NDEST*PREG_W-1:0]  inc_rem_preg,
    output logic [NDEST-1:0]         inc_cpl_v,
    output logic [NDEST*PREG_W-1:0]  inc_cpl_preg
);
    pst_stat_t                   qry_stat;
    pst_stat_t                   sq_stat;
    logic [NDEST-1:0]            sq_pin;
    logic [NDEST*PREG_W-1:0]     sq_preg;

    pst_status_table #(.TAG_W(TAG_W), .NDEST(NDEST), .PREG_W(PREG_W)) u_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .ren_valid      (ren_valid),
        .ren_tag        (ren_tag),
        .ren_dst_valid  (ren_dst_valid),
        .ren_dst_pinned (ren_dst_pinned),
        .ren_dst_preg   (ren_dst_preg),
        .wr_valid       (wr_valid),
        .wr_tag         (wr_tag),
        .sq_valid       (sq_valid),
        .sq_tag         (sq_tag),
        .sq_from_lsq    (sq_from_lsq),
        .qry_tag        (qry_tag),
        .qry_stat       (qry_stat),
        .sq_stat        (sq_stat),
        .sq_pin         (sq_pin),
        .sq_preg        (sq_preg)
    );

    pst_restore_gen #(.NDEST(NDEST), .PREG_W(PREG_W)) u_restore (
        .clk          (clk),
        .rst_n        (rst_n),
        .sq_valid     (sq_valid),
        .sq_stat      (sq_stat),
        .sq_pin       (sq_pin),
        .sq_preg      (sq_preg),
        .inc_rem_v    (inc_rem_v),
        .inc_rem_preg (inc_rem_preg),
        .inc_cpl_v    (inc_cpl_v),
        .inc_cpl_preg (inc_cpl_preg)
    );

    assign qry_squashed     = qry_stat.squashed;
    assign qry_lsq_squashed = qry_stat.lsq_sq;
    assign qry_renamed      = qry_stat.renamed;
    assign qry_written      = qry_stat.written;
    assign qry_sqdone       = qry_stat.sqdone;

endmodule

// File: rtl/pst_tracker_chk.sv
// Property checker for pin_squash_tracker, attached by bind below.
// Assumes: observes only the ports of the top module.
module pst_tracker_chk #(
    parameter int TAG_W  = 3,
    parameter int NDEST  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ren_valid,
    input logic [TAG_W-1:0] ren_tag,
    input logic             sq_valid,
    input logic [TAG_W-1:0] sq_tag,
    input logic [TAG_W-1:0] qry_tag,
    input logic             qry_squashed,
    input logic             qry_renamed,
    input logic             qry_written,
    input logic             qry_sqdone,
    input logic [NDEST-1:0] inc_rem_v,
    input logic [NDEST-1:0] inc_cpl_v
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (inc_rem_v == '0 && inc_cpl_v == '0)); // R1

    AST_WRITTEN_NEEDS_RENAMED: assert property (@(posedge clk) disable iff (!rst_n)
        qry_written |-> qry_renamed); // R3

    AST_STROBE_AFTER_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_rem_v != '0) |-> $past(sq_valid)); // R5

    AST_CPL_WITHIN_REM: assert property (@(posedge clk) disable iff (!rst_n)
        ((inc_cpl_v & ~inc_rem_v) == '0)); // R6

    AST_DONE_NEEDS_SQUASHED: assert property (@(posedge clk) disable iff (!rst_n)
        qry_sqdone |-> qry_squashed); // R7

    AST_SECOND_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && qry_tag == sq_tag && qry_sqdone && !(ren_valid && ren_tag == sq_tag))
        |=> (inc_rem_v == '0 && inc_cpl_v == '0)); // R7

endmodule

bind pin_squash_tracker pst_tracker_chk #(.TAG_W(TAG_W), .NDEST(NDEST)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_valid    (ren_valid),
    .ren_tag      (ren_tag),
    .sq_valid     (sq_valid),
    .sq_tag       (sq_tag),
    .qry_tag      (qry_tag),
    .qry_squashed (qry_squashed),
    .qry_renamed  (qry_renamed),
    .qry_written  (qry_written),
    .qry_sqdone   (qry_sqdone),
    .inc_rem_v    (inc_rem_v),
    .inc_cpl_v    (inc_cpl_v)
);

// File: tb/tb_pin_squash_tracker.sv
// Sweep of every lane pattern and completion history for the tracker.
module tb_pin_squash_tracker;
    localparam int TAG_W  = 3;
    localparam int NDEST  = 2;
    localparam int PREG_W = 5;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    ren_valid = 1'b0;
    logic [TAG_W-1:0]        ren_tag = '0;
    logic [NDEST-1:0]        ren_dst_valid = '0;
    logic [NDEST-1:0]        ren_dst_pinned = '0;
    logic [NDEST*PREG_W-1:0] ren_dst_preg = '0;
    logic                    wr_valid = 1'b0;
    logic [TAG_W-1:0]        wr_tag = '0;
    logic                    sq_valid = 1'b0;
    logic [TAG_W-1:0]        sq_tag = '0;
    logic                    sq_from_lsq = 1'b0;
    logic [TAG_W-1:0]        qry_tag = '0;
    logic                    qry_squashed, qry_lsq_squashed, qry_renamed, qry_written, qry_sqdone;
    logic [NDEST-1:0]        inc_rem_v, inc_cpl_v;
    logic [NDEST*PREG_W-1:0] inc_rem_preg, inc_cpl_preg;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pin_squash_tracker #(.TAG_W(TAG_W), .NDEST(NDEST), .PREG_W(PREG_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_tag(ren_tag), .ren_dst_valid(ren_dst_valid),
        .ren_dst_pinned(ren_dst_pinned), .ren_dst_preg(ren_dst_preg),
        .wr_valid(wr_valid), .wr_tag(wr_tag),
        .sq_valid(sq_valid), .sq_tag(sq_tag), .sq_from_lsq(sq_from_lsq),
        .qry_tag(qry_tag), .qry_squashed(qry_squashed), .qry_lsq_squashed(qry_lsq_squashed),
        .qry_renamed(qry_renamed), .qry_written(qry_written), .qry_sqdone(qry_sqdone),
        .inc_rem_v(inc_rem_v), .inc_rem_preg(inc_rem_preg),
        .inc_cpl_v(inc_cpl_v), .inc_cpl_preg(inc_cpl_preg)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance past one rising edge and settle away from it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_inputs();
        ren_valid = 1'b0; wr_valid = 1'b0; sq_valid = 1'b0; sq_from_lsq = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        tick(); tick();
        // R1: reset state of every entry and the strobes.
        for (int t = 0; t < (1 << TAG_W); t++) begin
            qry_tag = TAG_W'(t);
            #1;
            chk("R1 flags", int'({qry_squashed, qry_lsq_squashed, qry_renamed, qry_written, qry_sqdone}), 0);
        end
        chk("R1 strobes", int'({inc_rem_v, inc_cpl_v}), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 after release", int'({inc_rem_v, inc_cpl_v, qry_renamed, qry_squashed}), 0);

        for (int c = 0; c < 64; c++) begin
            logic [1:0] v, p, pin, mode;
            logic [TAG_W-1:0] tag;
            logic ren, wexp;
            v = c[1:0]; p = c[3:2]; mode = c[5:4];
            tag = c[2:0] ^ c[5:3];
            pin = v & p;
            ren = |pin;
            wexp = ren && (mode != 2'd0);
            qry_tag = tag;

            // Rename the entry.
            ren_valid = 1'b1; ren_tag = tag; ren_dst_valid = v; ren_dst_pinned = p;
            for (int d = 0; d < NDEST; d++)
                ren_dst_preg[d*PREG_W +: PREG_W] = PREG_W'(tag * 4 + d + 1);
            tick(); clear_inputs();
            chk("R2 renamed", int'(qry_renamed), int'(ren));
            chk("R2 cleared", int'({qry_written, qry_sqdone, qry_squashed, qry_lsq_squashed}), 0);

            // Completion before the squash.
            if (mode == 2'd1 || mode == 2'd3) begin
                wr_valid = 1'b1; wr_tag = tag;
                tick(); clear_inputs();
                chk("R3 written", int'(qry_written), int'(ren));
            end

            // First squash, with same-cycle completion in mode 2.
            sq_valid = 1'b1; sq_tag = tag; sq_from_lsq = (mode == 2'd3);
            if (mode == 2'd2) begin wr_valid = 1'b1; wr_tag = tag; end
            tick(); clear_inputs();
            chk("R5 rename credit lanes", int'(inc_rem_v), int'(ren ? pin : 2'b00));
            chk("R6 R8 completion credit lanes", int'(inc_cpl_v), int'(wexp ? pin : 2'b00));
            for (int d = 0; d < NDEST; d++)
                if (pin[d]) begin
                    chk("R5 preg", int'(inc_rem_preg[d*PREG_W +: PREG_W]), tag * 4 + d + 1);
                    if (wexp)
                        chk("R6 preg", int'(inc_cpl_preg[d*PREG_W +: PREG_W]), tag * 4 + d + 1);
                end
            chk("R4 squashed", int'(qry_squashed), 1);
            chk("R4 lsq squashed", int'(qry_lsq_squashed), int'(mode == 2'd3));
            chk("R7 squash done", int'(qry_sqdone), int'(ren));
            chk("R8 written after squash", int'(qry_written), int'(wexp));

            tick();
            chk("R5 one-cycle strobe", int'({inc_rem_v, inc_cpl_v}), 0);

            // Second squash plus a late completion.
            sq_valid = 1'b1; sq_tag = tag; wr_valid = 1'b1; wr_tag = tag;
            tick(); clear_inputs();
            chk("R7 second squash quiet", int'({inc_rem_v, inc_cpl_v}), 0);
            chk("R3 late completion ignored", int'(qry_written), int'(wexp));
            chk("R7 done held", int'(qry_sqdone), int'(ren));
            tick();
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule